// File: doc/BRIEF.md
# Mode-Steered Memory Loader and Input Collector

This block is the front end of a table-driven evaluator. A single 12-bit data port, qualified by a valid strobe, serves three uses. A 2-bit mode input picks the use. In run mode, four successive valid words fill the four evaluation inputs. After the fourth word the block sends a one-cycle start pulse to the evaluator. In the two programming modes, successive words are packed into write transactions for a 16384x12 tree memory or a 4096x60 parameter memory. The block generates the addresses and write strobes itself.

A tree word takes two beats and a parameter word takes six, so a full memory load needs 32768 or 24576 valid cycles. The fourth mode code selects test. That code only raises a test enable. Any change of mode restarts all sequencing. When fewer than four evaluation inputs are in use, the slots above the selected count are stored as zero.

Top module: `prog_front_end`

## Requirements
- R1: `test_en_o` is high exactly in the cycles where `mode_i` is 2'b11. Valid beats in that mode produce no memory write and no start pulse. Mode codes: 2'b00 run, 2'b01 tree write, 2'b10 parameter write, 2'b11 test.
- R2: In tree mode, valid beats are taken in pairs. The first beat of a pair latches `data_i`. The second beat causes `tree_we_o` to be high for exactly the following cycle, with `tree_wdata_o` equal to the latched word.
- R3: Tree write addresses start at 0 on entry to tree mode and rise by one per word. After 16383 they wrap to 0.
- R4: In parameter mode, five valid beats carry the fields of a 60-bit word, most significant first (the first field lands in bits 59:48). A sixth valid beat causes `par_we_o` to be high for exactly the following cycle, with the assembled `par_wdata_o`. The data on the sixth beat is ignored.
- R5: Parameter write addresses start at 0 on entry to parameter mode and rise by one per committed word.
- R6: In run mode, valid beats fill slots 1 to 4 in order. Slot k appears on `x_o[12k-1:12k-12]`. `start_o` is high for exactly the cycle after the fourth beat, and the next beat fills slot 1 again.
- R7: `n_in_i` holds the number of used inputs minus one. A run-mode beat into a slot above that count stores zero in place of `data_i`.
- R8: A cycle whose `mode_i` differs from the previous cycle's restarts the beat, slot and address counters. A partly assembled word is dropped, and a valid beat in that cycle counts as the first beat.
- R9: Cycles with `valid_i` low advance no counter and change no output other than ending a one-cycle strobe.
- R10: After reset every strobe is low, `x_o` is zero and the previous mode is taken as run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Mode select |
| valid_i | input | 1 | Qualifies `data_i` as a beat |
| data_i | input | 12 | Shared data port |
| n_in_i | input | 2 | Number of used inputs minus one |
| tree_we_o | output | 1 | Tree memory write strobe |
| tree_addr_o | output | 14 | Tree memory write address |
| tree_wdata_o | output | 12 | Tree memory write data |
| par_we_o | output | 1 | Parameter memory write strobe |
| par_addr_o | output | 12 | Parameter memory write address |
| par_wdata_o | output | 60 | Parameter memory write data |
| x_o | output | 48 | Four collected inputs, slot 1 in the low bits |
| start_o | output | 1 | One-cycle evaluation start |
| test_en_o | output | 1 | Test mode enable |

## Verification
The bench builds the block with its default parameters: 12-bit words, a 14-bit tree address, a 12-bit parameter address, five fields and four inputs. With these sizes a full tree pass of 16384 words fits in the run, so the address wrap from 16383 to 0 is exercised directly. The bench also covers input counts from one to four, idle gaps inside words, and partial parameter words cut off by a mode change. Test-mode beats are applied and checked as well.

// File: rtl/pfe_pkg.sv
package pfe_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_TREE  = 2'b01,
    MODE_PARAM = 2'b10,
    MODE_TEST  = 2'b11
  } mode_e;
endpackage

// File: rtl/pfe_tree_wr.sv
module pfe_tree_wr #(
  parameter int DW  = 12,
  parameter int TAW = 14
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           beat_i,
  input  logic [DW-1:0]  data_i,
  output logic           we_o,
  output logic [TAW-1:0] addr_o,
  output logic [DW-1:0]  wdata_o
);
  logic           phase_q, phase_eff;
  logic [TAW-1:0] addr_q, addr_eff;
  logic [DW-1:0]  lat_q;

  assign phase_eff = clr_i ? 1'b0 : phase_q;
  assign addr_eff  = clr_i ? '0 : addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      addr_q  <= '0;
      lat_q   <= '0;
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      we_o <= 1'b0;
      if (beat_i) begin
        if (!phase_eff) begin
          lat_q   <= data_i;
          phase_q <= 1'b1;
          addr_q  <= addr_eff;
        end else begin
          we_o    <= 1'b1;
          addr_o  <= addr_eff;
          wdata_o <= lat_q;
          addr_q  <= addr_eff + TAW'(1);
          phase_q <= 1'b0;
        end
      end else if (clr_i) begin
        phase_q <= 1'b0;
        addr_q  <= '0;
      end
    end
  end

  AST_TREE_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o); // R2
  AST_TREE_ADDR_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && !clr_i) |-> (addr_q == addr_o + TAW'(1))); // R3
endmodule

// File: rtl/pfe_par_wr.sv
module pfe_par_wr #(
  parameter int DW     = 12,
  parameter int PAW    = 12,
  parameter int NFIELD = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 beat_i,
  input  logic [DW-1:0]        data_i,
  output logic                 we_o,
  output logic [PAW-1:0]       addr_o,
  output logic [DW*NFIELD-1:0] wdata_o
);
  localparam int PW = DW * NFIELD;
  localparam int CW = $clog2(NFIELD + 1);

  logic [CW-1:0]  cnt_q, cnt_eff;
  logic [PAW-1:0] addr_q, addr_eff;
  logic [PW-1:0]  sh_q;

  assign cnt_eff  = clr_i ? '0 : cnt_q;
  assign addr_eff = clr_i ? '0 : addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      addr_q  <= '0;
      sh_q    <= '0;
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      we_o <= 1'b0;
      if (beat_i) begin
        addr_q <= addr_eff;
        if (cnt_eff == CW'(NFIELD)) begin
          we_o    <= 1'b1;
          addr_o  <= addr_eff;
          wdata_o <= sh_q;
          addr_q  <= addr_eff + PAW'(1);
          cnt_q   <= '0;
        end else begin
          // earlier fields move up; a full word replaces all bits
          sh_q  <= {sh_q[PW-DW-1:0], data_i};
          cnt_q <= cnt_eff + CW'(1);
        end
      end else if (clr_i) begin
        cnt_q  <= '0;
        addr_q <= '0;
      end
    end
  end

  AST_PAR_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o); // R4
  AST_PAR_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(NFIELD)); // R4
endmodule

// File: rtl/pfe_in_acq.sv
module pfe_in_acq #(
  parameter int DW  = 12,
  parameter int NIN = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     beat_i,
  input  logic [DW-1:0]            data_i,
  input  logic [$clog2(NIN)-1:0]   n_in_i,
  output logic [DW*NIN-1:0]        x_o,
  output logic                     start_o
);
  localparam int SW = $clog2(NIN);

  logic [SW-1:0] slot_q, slot_eff;
  logic [DW-1:0] x_q [NIN];

  assign slot_eff = clr_i ? '0 : slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      start_o <= 1'b0;
    end else begin
      start_o <= 1'b0;
      if (beat_i) begin
        if (slot_eff == SW'(NIN - 1)) begin
          start_o <= 1'b1;
          slot_q  <= '0;
        end else begin
          slot_q <= slot_eff + SW'(1);
        end
      end else if (clr_i) begin
        slot_q <= '0;
      end
    end
  end

  for (genvar k = 0; k < NIN; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        x_q[k] <= '0;
      end else if (beat_i && slot_eff == SW'(k)) begin
        x_q[k] <= (SW'(k) <= n_in_i) ? data_i : '0;
      end
    end
    assign x_o[k*DW +: DW] = x_q[k];
  end

  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R6
  AST_TOP_SLOT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && $stable(n_in_i) && n_in_i != SW'(NIN - 1)) |-> (x_q[NIN-1] == '0)); // R7
endmodule

// File: rtl/prog_front_end.sv
module prog_front_end
  import pfe_pkg::*;
#(
  parameter int DW     = 12,
  parameter int TAW    = 14,
  parameter int PAW    = 12,
  parameter int NFIELD = 5,
  parameter int NIN    = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               mode_i,
  input  logic                     valid_i,
  input  logic [DW-1:0]            data_i,
  input  logic [$clog2(NIN)-1:0]   n_in_i,
  output logic                     tree_we_o,
  output logic [TAW-1:0]           tree_addr_o,
  output logic [DW-1:0]            tree_wdata_o,
  output logic                     par_we_o,
  output logic [PAW-1:0]           par_addr_o,
  output logic [DW*NFIELD-1:0]     par_wdata_o,
  output logic [DW*NIN-1:0]        x_o,
  output logic                     start_o,
  output logic                     test_en_o
);
  mode_e mode, mode_q;
  logic  chg;

  assign mode = mode_e'(mode_i);
  assign chg  = (mode != mode_q);
  assign test_en_o = (mode == MODE_TEST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_RUN;
    else         mode_q <= mode;
  end

  pfe_tree_wr #(.DW(DW), .TAW(TAW)) u_tree (
    .clk_i, .rst_ni, .clr_i(chg),
    .beat_i(valid_i && mode == MODE_TREE), .data_i,
    .we_o(tree_we_o), .addr_o(tree_addr_o), .wdata_o(tree_wdata_o)
  );

  pfe_par_wr #(.DW(DW), .PAW(PAW), .NFIELD(NFIELD)) u_par (
    .clk_i, .rst_ni, .clr_i(chg),
    .beat_i(valid_i && mode == MODE_PARAM), .data_i,
    .we_o(par_we_o), .addr_o(par_addr_o), .wdata_o(par_wdata_o)
  );

  pfe_in_acq #(.DW(DW), .NIN(NIN)) u_acq (
    .clk_i, .rst_ni, .clr_i(chg),
    .beat_i(valid_i && mode == MODE_RUN), .data_i, .n_in_i,
    .x_o, .start_o
  );

  AST_TEST_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_TEST && $past(mode_i) == 2'b11) |-> !(tree_we_o || par_we_o || start_o)); // R1
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tree_we_o, par_we_o, start_o})); // R8
endmodule

// File: tb/prog_front_end_test.sv
module prog_front_end_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        valid = 1'b0;
  logic [11:0] data = '0;
  logic [1:0]  n_in = 2'd3;
  logic        tree_we, par_we, start, test_en;
  logic [13:0] tree_addr;
  logic [11:0] tree_wdata, par_addr;
  logic [59:0] par_wdata;
  logic [47:0] x;

  int checks = 0, errors = 0;
  int tw_cnt = 0, pw_cnt = 0, st_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prog_front_end uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .valid_i(valid), .data_i(data),
    .n_in_i(n_in), .tree_we_o(tree_we), .tree_addr_o(tree_addr),
    .tree_wdata_o(tree_wdata), .par_we_o(par_we), .par_addr_o(par_addr),
    .par_wdata_o(par_wdata), .x_o(x), .start_o(start), .test_en_o(test_en)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference
  int          m_prev = 0, t_ph = 0, t_addr = 0, p_addr = 0, slot = 0;
  logic [11:0] t_lat = '0;
  logic [11:0] pq[$];
  logic [11:0] xs [4] = '{default: '0};
  bit          e_twe = 0, e_pwe = 0, e_st = 0;
  int          e_taddr = 0, e_paddr = 0;
  logic [11:0] e_tdata = '0;
  logic [59:0] e_pdata = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev = 0; t_ph = 0; t_addr = 0; p_addr = 0; slot = 0;
      pq.delete(); e_twe = 0; e_pwe = 0; e_st = 0;
      foreach (xs[i]) xs[i] = '0;
    end else begin
      e_twe = 0; e_pwe = 0; e_st = 0;
      if (int'(mode) != m_prev) begin
        t_ph = 0; t_addr = 0; p_addr = 0; slot = 0; pq.delete();
      end
      m_prev = int'(mode);
      if (valid) begin
        case (mode)
          2'b01: if (t_ph == 0) begin t_lat = data; t_ph = 1; end
                 else begin
                   e_twe = 1; e_taddr = t_addr; e_tdata = t_lat;
                   t_addr = (t_addr + 1) % 16384; t_ph = 0;
                 end
          2'b10: if (pq.size() < 5) pq.push_back(data);
                 else begin
                   e_pwe = 1; e_paddr = p_addr; e_pdata = '0;
                   foreach (pq[i]) e_pdata = (e_pdata << 12) | 60'(pq[i]);
                   pq.delete(); p_addr = (p_addr + 1) % 4096;
                 end
          2'b00: begin
                   xs[slot] = (slot <= int'(n_in)) ? data : 12'h0;
                   if (slot == 3) begin e_st = 1; slot = 0; end
                   else slot++;
                 end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(test_en == (mode == 2'b11), "R1", "test_en", 64'(test_en), 64'(mode == 2'b11));
    chk(tree_we == e_twe, "R2", "tree_we", 64'(tree_we), 64'(e_twe));
    if (e_twe) begin
      chk(tree_wdata == e_tdata, "R2", "tree_wdata", 64'(tree_wdata), 64'(e_tdata));
      chk(int'(tree_addr) == e_taddr, "R3", "tree_addr", 64'(tree_addr), 64'(e_taddr));
    end
    chk(par_we == e_pwe, "R4", "par_we", 64'(par_we), 64'(e_pwe));
    if (e_pwe) begin
      chk(par_wdata == e_pdata, "R4", "par_wdata", 64'(par_wdata), 64'(e_pdata));
      chk(int'(par_addr) == e_paddr, "R5", "par_addr", 64'(par_addr), 64'(e_paddr));
    end
    chk(start == e_st, "R6", "start", 64'(start), 64'(e_st));
    chk(x == {xs[3], xs[2], xs[1], xs[0]}, "R7", "x",
        64'(x), 64'({xs[3], xs[2], xs[1], xs[0]}));
    if (tree_we) tw_cnt++;
    if (par_we)  pw_cnt++;
    if (start)   st_cnt++;
  end

  task automatic beat(input logic [11:0] d);
    @(negedge clk); #1; valid = 1'b1; data = d;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; valid = 1'b0; data = 12'hAAA; end
  endtask
  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); #1; valid = 1'b0; mode = m;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    chk({tree_we, par_we, start} == 3'b000, "R10", "strobes in reset", 64'({tree_we, par_we, start}), 0);
    chk(x == '0, "R10", "x in reset", 64'(x), 0);
    #1 rst_n = 1'b1;
    idle(2);
    // tree mode with gaps
    set_mode(2'b01);
    beat(12'h123); beat(12'h456); beat(12'h789); idle(5);
    c = tw_cnt;
    idle(1);
    chk(tw_cnt == c, "R9", "no write across idle gap", 64'(tw_cnt), 64'(c));
    beat(12'hABC); beat(12'hDEF); beat(12'h001); idle(2);
    // parameter mode
    set_mode(2'b10);
    for (int w = 0; w < 3; w++) begin
      for (int f = 0; f < 5; f++) begin beat(12'(w * 16 + f + 12'h300)); if (f == 2) idle(2); end
      beat(12'hFFF);
    end
    // partial word, then leave and re-enter
    beat(12'h111); beat(12'h222); beat(12'h333);
    set_mode(2'b00); set_mode(2'b10);
    for (int f = 0; f < 5; f++) beat(12'(f + 12'h700));
    beat(12'h000); idle(1);
    chk(par_we && par_addr == 12'd0 && par_wdata == 60'h700_701_702_703_704,
        "R8", "parameter restart", 64'(par_addr), 0);
    // mode change cycle beat counts as first beat
    @(negedge clk); #1; mode = 2'b01; valid = 1'b1; data = 12'h5A5;
    beat(12'h0); idle(1);
    chk(tree_we && tree_addr == 14'd0 && tree_wdata == 12'h5A5, "R8", "tree entry beat",
        64'(tree_wdata), 64'h5A5);
    // run mode, all counts
    set_mode(2'b00);
    for (int n = 3; n >= 0; n--) begin
      n_in = 2'(n);
      for (int k = 0; k < 4; k++) begin beat(12'(12'h900 + n * 4 + k)); if (k == 1) idle(1); end
      idle(1);
    end
    // partial run load dropped by mode change
    n_in = 2'd3;
    beat(12'hB01); beat(12'hB02);
    set_mode(2'b11);
    c = st_cnt;
    beat(12'hC01); beat(12'hC02); beat(12'hC03); beat(12'hC04); beat(12'hC05); beat(12'hC06);
    idle(2);
    chk(st_cnt == c, "R1", "no start in test mode", 64'(st_cnt), 64'(c));
    set_mode(2'b00);
    for (int k = 0; k < 4; k++) beat(12'(12'hD00 + k));
    idle(2);
    // full tree pass with wrap
    set_mode(2'b01);
    c = tw_cnt;
    for (int w = 0; w < 16386; w++) begin beat(12'(w)); beat(12'(~w)); end
    idle(2);
    chk(tw_cnt == c + 16386, "R3", "writes over wrap", 64'(tw_cnt), 64'(c + 16386));
    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule